// File: doc/BRIEF.md
# Snapshot Free-Running Counter

This block keeps a 64-bit counter that advances by one on every clock cycle in which its tick input is high. Software never reads the running value directly. It works through a small register port with three word addresses: two 32-bit snapshot words and a command word. Writing the command word with the latch bit set copies the whole running count into the snapshot pair in a single step. Reading the two halves afterwards then gives one coherent 64-bit value, even though the counter keeps moving. Writing the clear bit zeroes the snapshot pair instead. Software may also overwrite either snapshot word directly.

The register port carries no data stream, so it has no valid/ready pair and applies no back-pressure. A write is accepted in the cycle `bus_wr` is high. Read data is a combinational function of `bus_addr` and the stored snapshot. The command bits act once and are never stored. The running counter is not affected by any register access.

Top module: `snapcnt_top`

## Requirements
- R1: After reset, the low snapshot word (address 0x0), the high snapshot word (address 0x4) and the command word (address 0x8) all read 0.
- R2: The running count increases by exactly one at each rising clock edge where `tick` is 1, and holds otherwise.
- R3: A write to 0x8 with bit 1 (latch) set and bit 0 clear copies the running count as it stands at that edge into the snapshot. Count bits 31:0 go to the low word and bits 63:32 to the high word, and both are visible from the next cycle.
- R4: A write to 0x8 with bit 0 (clear) set makes both snapshot words read 0 from the next cycle.
- R5: A write to 0x8 with both bit 0 and bit 1 set leaves both snapshot words at 0. The copy is applied first and the zeroing after it.
- R6: The command word always reads 0, including right after a write with bits 0 or 1 set.
- R7: A write to 0x0 or 0x4 replaces only the addressed snapshot word with the written data.
- R8: The snapshot words change only through R3, R4, R5 or R7; ticks alone never alter what is read.
- R9: Latch and clear commands do not disturb the running count. A later latch returns the number of ticks counted since reset.
- R10: Reads from any other address return 0, and writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one increment per high cycle |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |

## Verification
The hardest case to reach from the ports is a command that lands on a cycle where `tick` is also high. The snapshot must then hold the pre-increment value, while the running count still advances. The bench therefore drives `tick` at random with high density on every cycle, including command cycles. Each latch result is compared with a bench-side tick tally. Long random runs mix latch, clear, combined commands, direct word writes and stray addresses, so that a latch after a clear shows that the count was never reset.

// File: rtl/snapcnt_pkg.sv
package snapcnt_pkg;
  // command word bit positions
  localparam int CMD_CLEAR_BIT = 0;
  localparam int CMD_LATCH_BIT = 1;

  typedef struct packed {
    logic latch;
    logic clear;
  } snap_cmd_t;

  // byte address of word index k
  function automatic int word_byte_addr(input int k);
    return k * 4;
  endfunction
endpackage

// File: rtl/snapcnt_counter.sv
module snapcnt_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (tick) count <= count + CNT_W'(1);
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count == $past(count) + CNT_W'(1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count)); // R9
endmodule

// File: rtl/snapcnt_decode.sv
module snapcnt_decode
  import snapcnt_pkg::*;
#(
  parameter int NWORDS = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [NWORDS-1:0] word_sel,
  output logic              ctrl_sel,
  output logic [NWORDS-1:0] word_we,
  output snap_cmd_t         cmd
);
  for (genvar k = 0; k < NWORDS; k++) begin : g_sel
    assign word_sel[k] = (bus_addr == ADDR_W'(word_byte_addr(k)));
  end

  assign ctrl_sel = (bus_addr == ADDR_W'(word_byte_addr(NWORDS)));
  assign word_we  = bus_wr ? word_sel : '0;

  always_comb begin
    cmd       = '0;
    if (bus_wr && ctrl_sel) begin
      cmd.latch = bus_wdata[CMD_LATCH_BIT];
      cmd.clear = bus_wdata[CMD_CLEAR_BIT];
    end
  end

  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_sel, word_sel})); // R10
endmodule

// File: rtl/snapcnt_bank.sv
module snapcnt_bank
  import snapcnt_pkg::*;
#(
  parameter int NWORDS = 2,
  parameter int DATA_W = 32,
  localparam int CNT_W = NWORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count,
  input  snap_cmd_t         cmd,
  input  logic [NWORDS-1:0] word_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  snap
);
  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        snap[k*DATA_W +: DATA_W] <= '0;
      end else if (cmd.clear) begin
        // clear is applied after latch, so it wins
        snap[k*DATA_W +: DATA_W] <= '0;
      end else if (cmd.latch) begin
        snap[k*DATA_W +: DATA_W] <= count[k*DATA_W +: DATA_W];
      end else if (word_we[k]) begin
        snap[k*DATA_W +: DATA_W] <= wdata;
      end
    end

    AST_WORD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      word_we[k] |=> snap[k*DATA_W +: DATA_W] == $past(wdata)); // R7
  end

  AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.latch && !cmd.clear) |=> snap == $past(count)); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.clear |=> snap == '0); // R4 R5
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.clear && !cmd.latch && word_we == '0) |=> $stable(snap)); // R8
endmodule

// File: rtl/snapcnt_top.sv
module snapcnt_top #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  import snapcnt_pkg::*;

  localparam int NWORDS = CNT_W / DATA_W;

  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  snap;
  logic [NWORDS-1:0] word_sel;
  logic [NWORDS-1:0] word_we;
  logic              ctrl_sel;
  snap_cmd_t         cmd;

  snapcnt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .count (count)
  );

  snapcnt_decode #(.NWORDS(NWORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .word_sel  (word_sel),
    .ctrl_sel  (ctrl_sel),
    .word_we   (word_we),
    .cmd       (cmd)
  );

  snapcnt_bank #(.NWORDS(NWORDS), .DATA_W(DATA_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .count   (count),
    .cmd     (cmd),
    .word_we (word_we),
    .wdata   (bus_wdata),
    .snap    (snap)
  );

  // read mux: command word and stray addresses read zero
  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NWORDS; k++) begin
      if (word_sel[k]) bus_rdata = snap[k*DATA_W +: DATA_W];
    end
  end

  AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_sel |-> bus_rdata == '0); // R6
endmodule

// File: tb/snapcnt_top_bench.sv
module snapcnt_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_LO = 4'h0, A_HI = 4'h4, A_CMD = 4'h8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] m_count;
  logic [63:0] m_snap;

  always #(CLK_PERIOD/2) clk = ~clk;

  snapcnt_top u_snapcnt_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] exp_read(input logic [3:0] a, input logic [63:0] s);
    if (a == A_LO) return s[31:0];
    if (a == A_HI) return s[63:32];
    return 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, return read data, update model at posedge
  task automatic cycle(input logic wr, input logic [3:0] a, input logic [31:0] wd,
                       input logic tk, output logic [31:0] rd);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = wd; tick = tk;
    #1 rd = bus_rdata;
    @(posedge clk);
    if (wr) begin
      if (a == A_LO) m_snap[31:0] = wd;
      else if (a == A_HI) m_snap[63:32] = wd;
      else if (a == A_CMD) begin
        if (wd[1]) m_snap = m_count;
        if (wd[0]) m_snap = '0;
      end
    end
    if (tk) m_count = m_count + 64'd1;
  endtask

  task automatic rd_check(input string req, input logic [3:0] a);
    logic [31:0] r;
    logic [31:0] e;
    e = exp_read(a, m_snap);
    cycle(1'b0, a, $urandom, $urandom_range(0, 1) == 1, r);
    check(req, r, e);
  endtask

  task automatic wr_op(input logic [3:0] a, input logic [31:0] wd, input logic tk);
    logic [31:0] r;
    cycle(1'b1, a, wd, tk, r);
  endtask

  task automatic idle(input int n, input logic tk);
    logic [31:0] r;
    for (int i = 0; i < n; i++) cycle(1'b0, A_CMD, 32'h0, tk, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] wd;
    int op;
    void'($urandom(32'd4242));
    m_count = '0;
    m_snap  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    begin
      logic [31:0] r;
      cycle(1'b0, A_LO, 0, 1'b0, r);  check("R1 lo", r, 32'h0);
      cycle(1'b0, A_HI, 0, 1'b0, r);  check("R1 hi", r, 32'h0);
      cycle(1'b0, A_CMD, 0, 1'b0, r); check("R1 cmd", r, 32'h0);
    end

    // R2/R3: 25 ticks then latch on a tick cycle
    idle(25, 1'b1);
    wr_op(A_CMD, 32'h2, 1'b1);
    rd_check("R3 latch lo", A_LO);
    rd_check("R3 latch hi", A_HI);
    begin
      logic [31:0] r;
      wr_op(A_CMD, 32'h2, 1'b0);
      cycle(1'b0, A_LO, 0, 1'b0, r);
      check("R2 tick tally", r, m_count[31:0]);
    end

    // R8: ticks alone keep snapshot
    idle(40, 1'b1);
    rd_check("R8 hold lo", A_LO);

    // R7 direct writes
    wr_op(A_HI, 32'hDEAD_BEEF, 1'b1);
    rd_check("R7 hi write", A_HI);
    rd_check("R7 lo untouched", A_LO);
    wr_op(A_LO, 32'h1234_5678, 1'b0);
    rd_check("R7 lo write", A_LO);

    // R6 command reads zero after command
    wr_op(A_CMD, 32'h3, 1'b1);
    rd_check("R6 cmd readback", A_CMD);
    // R5 both bits -> zero
    rd_check("R5 both lo", A_LO);
    rd_check("R5 both hi", A_HI);

    // R4 clear after direct writes
    wr_op(A_HI, 32'hA5A5_0001, 1'b0);
    wr_op(A_CMD, 32'h1, 1'b1);
    rd_check("R4 clear hi", A_HI);
    rd_check("R4 clear lo", A_LO);

    // R9 latch after clear shows unbroken count
    idle(7, 1'b1);
    wr_op(A_CMD, 32'h2, 1'b0);
    rd_check("R9 count survives clear", A_LO);

    // R10 stray addresses
    wr_op(A_LO, 32'h0BAD_F00D, 1'b0);
    wr_op(4'hC, 32'hFFFF_FFFF, 1'b1);
    wr_op(4'h1, 32'hFFFF_FFFF, 1'b1);
    rd_check("R10 stray read C", 4'hC);
    rd_check("R10 stray read 1", 4'h1);
    rd_check("R10 lo intact", A_LO);
    rd_check("R10 hi intact", A_HI);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      op = $urandom_range(0, 9);
      wd = $urandom;
      case (op)
        0: wr_op(A_CMD, 32'h2, $urandom_range(0, 3) != 0);           // R3
        1: wr_op(A_CMD, 32'h1 | (wd & 32'hFFFF_FFFC), $urandom_range(0, 1) == 1); // R4
        2: wr_op(A_CMD, 32'h3, $urandom_range(0, 1) == 1);           // R5
        3: wr_op(A_LO, wd, $urandom_range(0, 1) == 1);               // R7
        4: wr_op(A_HI, wd, $urandom_range(0, 1) == 1);               // R7
        5: wr_op(4'(($urandom_range(0, 1) == 1) ? 4'hC : 4'(wd[3:0] | 4'h1)), wd, 1'b1); // R10
        6: idle($urandom_range(1, 20), $urandom_range(0, 3) != 0);   // R8
        default: ;
      endcase
      rd_check("R3/R9 rand lo", A_LO);
      rd_check("R7 rand hi", A_HI);
      if (i % 16 == 0) rd_check("R6 rand cmd", A_CMD);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule